// File: doc/BRIEF.md
# H-Bridge Control Decoder with Fault Latch

This block turns the direction and control pins of a full H-bridge into a drive code for each half-bridge leg. Each leg can be driven high, driven low, or left in tristate. When the bridge is switched on and no fault is present, every leg copies its own direction pin. If the disable pin is high or the enable pin is low, every leg goes to tristate. A pin can be marked as floating. A floating pin then reads its tie value: direction pins and the disable pin read high, and the enable pin reads low.

The protection circuits report faults as single-cycle pulses that are synchronous to the block clock. The fault sources are a short to supply on each leg, a short to ground on each leg, a short across the load, and over-temperature. Each pulse sets a sticky bit. A bit stays set until one of three events clears it: a falling edge on the resolved disable pin, a rising edge on the resolved enable pin, or the synchronous power-on reset `rst`. Undervoltage is a live level and is not latched. It holds the legs in tristate only while it is present, and the legs recover by themselves once it goes away. While any latched fault or undervoltage is present, the active-low status flag is low. A serial readout block can read the fault register directly.

Top module: `hbridge_ctrl`

## Requirements
- R1: With the bridge on (resolved disable low and resolved enable high) and no fault, leg i drives code 2'b10 (high) when direction pin i is 1 and code 2'b01 (low) when it is 0. Leg i occupies `leg_o[2i+1:2i]`. Code 2'b11 never appears.
- R2: When the resolved disable pin is high or the resolved enable pin is low, every leg reads 2'b00 (tristate).
- R3: A pin whose float bit is set reads as its tie value, whatever its data input is. The tie value is 1 for direction and disable pins and 0 for the enable pin.
- R4: While `stat_o` has any bit set, every leg is 2'b00 and `flag_n_o` is 0. Once `stat_o` is all zero, `flag_n_o` returns to 1.
- R5: `stat_o[2N+2]` (N legs) follows `uv_i` one cycle later. Undervoltage forces tristate and a low flag only while it is present. Drive resumes on its own when it goes away.
- R6: A pulse on `flt_pulse_i[b]` sets `stat_o[b]` on the next cycle. Bit layout: [N-1:0] short to supply per leg, [2N-1:N] short to ground per leg, [2N] short across the load, [2N+1] over-temperature. When a pulse and a clear arrive in the same cycle, the pulse wins.
- R7: A latched bit clears only on a high-to-low edge of the resolved disable pin or a low-to-high edge of the resolved enable pin. Raising disable alone, or lowering enable alone, keeps the bit set.
- R8: The synchronous reset `rst` zeroes every fault bit and leaves every leg in tristate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| dir_i | input | NUM_LEGS | Direction pin per leg |
| dir_float_i | input | NUM_LEGS | Direction pin is unconnected |
| off_i | input | 1 | Disable pin, active high |
| off_float_i | input | 1 | Disable pin is unconnected |
| on_i | input | 1 | Enable pin, active high |
| on_float_i | input | 1 | Enable pin is unconnected |
| flt_pulse_i | input | 2*NUM_LEGS+2 | Fault pulses from the protection circuits |
| uv_i | input | 1 | Live undervoltage level |
| leg_o | output | 2*NUM_LEGS | Registered drive code per leg |
| flag_n_o | output | 1 | Active-low status flag |
| stat_o | output | 2*NUM_LEGS+3 | Latched fault bits plus live undervoltage in the top bit |

## Verification
The assertions take the fault pulses and `uv_i` to be synchronous to `clk`. The control pins may be asynchronous, because they pass through the synchronisers before any edge is detected. The stimulus changes every input only on the falling clock edge. It holds each control setting for several cycles before the outputs are compared, so every synchroniser stage and output register has settled. Fault pulses last exactly one cycle. Clearing is always done by moving a pin through its full transition, with no fault pulse in the same window.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    LEG_OFF  = 2'b00,
    LEG_SINK = 2'b01,
    LEG_SRC  = 2'b10
  } leg_code_e;
endpackage

// File: rtl/hbc_sync.sv
module hbc_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hbc_clear_det.sv
module hbc_clear_det (
  input  logic clk,
  input  logic rst,
  input  logic off_s_i,
  input  logic on_s_i,
  output logic clr_o
);
  logic off_prev, on_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_prev <= 1'b1;
      on_prev  <= 1'b0;
    end else begin
      off_prev <= off_s_i;
      on_prev  <= on_s_i;
    end
  end

  assign clr_o = (off_prev & ~off_s_i) | (~on_prev & on_s_i);
endmodule

// File: rtl/hbc_fault_latch.sv
module hbc_fault_latch #(
  parameter int FLT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [FLT_W-1:0] pulse_i,
  input  logic             uv_i,
  output logic [FLT_W-1:0] held_o,
  output logic             uv_o
);
  logic [FLT_W-1:0] kept;

  always_comb kept = clr_i ? '0 : held_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_o <= '0;
      uv_o   <= 1'b0;
    end else begin
      held_o <= kept | pulse_i;
      uv_o   <= uv_i;
    end
  end
endmodule

// File: rtl/hbc_leg_drive.sv
module hbc_leg_drive
  import hbc_pkg::*;
#(
  parameter int NUM_LEGS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_i,
  input  logic [NUM_LEGS-1:0]   dir_i,
  output logic [2*NUM_LEGS-1:0] leg_o
);
  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    leg_code_e nxt;
    always_comb begin
      if (!run_i)        nxt = LEG_OFF;
      else if (dir_i[g]) nxt = LEG_SRC;
      else               nxt = LEG_SINK;
    end
    always_ff @(posedge clk) begin
      if (rst) leg_o[2*g +: 2] <= LEG_OFF;
      else     leg_o[2*g +: 2] <= nxt;
    end
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int NUM_LEGS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int FLT_W      = 2*NUM_LEGS + 2,
  localparam int CTL_W      = NUM_LEGS + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEGS-1:0]   dir_i,
  input  logic [NUM_LEGS-1:0]   dir_float_i,
  input  logic                  off_i,
  input  logic                  off_float_i,
  input  logic                  on_i,
  input  logic                  on_float_i,
  input  logic [FLT_W-1:0]      flt_pulse_i,
  input  logic                  uv_i,
  output logic [2*NUM_LEGS-1:0] leg_o,
  output logic                  flag_n_o,
  output logic [FLT_W:0]        stat_o
);
  localparam logic [CTL_W-1:0] CTL_TIE = {1'b0, 1'b1, {NUM_LEGS{1'b1}}};

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic [FLT_W-1:0] held;
  logic             uv_q, clr_w, run_w;

  always_comb begin
    ctl_raw[NUM_LEGS-1:0] = (dir_i & ~dir_float_i) | dir_float_i;
    ctl_raw[NUM_LEGS]     = off_float_i ? 1'b1 : off_i;
    ctl_raw[NUM_LEGS+1]   = on_float_i  ? 1'b0 : on_i;
  end

  hbc_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_TIE)) u_sync (
    .clk(clk), .rst(rst), .d_i(ctl_raw), .q_o(ctl_s)
  );

  hbc_clear_det u_clr (
    .clk(clk), .rst(rst),
    .off_s_i(ctl_s[NUM_LEGS]), .on_s_i(ctl_s[NUM_LEGS+1]), .clr_o(clr_w)
  );

  hbc_fault_latch #(.FLT_W(FLT_W)) u_flt (
    .clk(clk), .rst(rst), .clr_i(clr_w), .pulse_i(flt_pulse_i),
    .uv_i(uv_i), .held_o(held), .uv_o(uv_q)
  );

  assign run_w = ~ctl_s[NUM_LEGS] & ctl_s[NUM_LEGS+1] & ~(|held) & ~uv_q;

  hbc_leg_drive #(.NUM_LEGS(NUM_LEGS)) u_legs (
    .clk(clk), .rst(rst), .run_i(run_w),
    .dir_i(ctl_s[NUM_LEGS-1:0]), .leg_o(leg_o)
  );

  always_ff @(posedge clk) begin
    if (rst) flag_n_o <= 1'b1;
    else     flag_n_o <= ~((|held) | uv_q);
  end

  assign stat_o = {uv_q, held};
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
  parameter int NUM_LEGS = 2,
  localparam int FLT_W   = 2*NUM_LEGS + 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [FLT_W-1:0]      flt_pulse_i,
  input logic                  uv_i,
  input logic [2*NUM_LEGS-1:0] leg_o,
  input logic                  flag_n_o,
  input logic [FLT_W:0]        stat_o,
  input logic                  clr_i
);
  logic bad_code;
  logic rst_d = 1'b0;

  always_comb begin
    bad_code = 1'b0;
    for (int g = 0; g < NUM_LEGS; g++)
      if (leg_o[2*g +: 2] == 2'b11) bad_code = 1'b1;
  end

  always_ff @(posedge clk) rst_d <= rst;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst) !bad_code); // R1
  AST_SHUT_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    (|stat_o) |=> (leg_o == '0 && !flag_n_o)); // R4
  AST_UV_FOLLOW_HI: assert property (@(posedge clk) disable iff (rst)
    uv_i |=> stat_o[FLT_W]); // R5
  AST_UV_FOLLOW_LO: assert property (@(posedge clk) disable iff (rst)
    !uv_i |=> !stat_o[FLT_W]); // R5
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
    (|flt_pulse_i) |=> ((stat_o[FLT_W-1:0] & $past(flt_pulse_i)) == $past(flt_pulse_i))); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_o[FLT_W-1:0] & $past(stat_o[FLT_W-1:0])) == $past(stat_o[FLT_W-1:0]))); // R7

  always @(posedge clk) begin
    if (rst_d) begin
      AST_POR_CLEAR: assert (stat_o[FLT_W-1:0] == '0 && leg_o == '0); // R8
    end
  end
endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.NUM_LEGS(NUM_LEGS)) u_chk (
  .clk(clk), .rst(rst), .flt_pulse_i(flt_pulse_i), .uv_i(uv_i),
  .leg_o(leg_o), .flag_n_o(flag_n_o), .stat_o(stat_o), .clr_i(clr_w)
);

// File: tb/hbridge_ctrl_bench.sv
`timescale 1ns/1ps
module hbridge_ctrl_bench;
  localparam int NL = 2;
  localparam int FW = 2*NL + 2;
  localparam int SETTLE = 6;

  typedef struct {
    logic [2*NL-1:0] legs;
    logic            flag;
    logic [FW:0]     stat;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] dir_i = '0, dir_float_i = '0;
  logic off_i = 1'b1, off_float_i = 1'b0, on_i = 1'b0, on_float_i = 1'b0;
  logic [FW-1:0] flt_pulse_i = '0;
  logic uv_i = 1'b0;
  logic [2*NL-1:0] leg_o;
  logic flag_n_o;
  logic [FW:0] stat_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  hbridge_ctrl #(.NUM_LEGS(NL)) u_hbridge_ctrl (
    .clk(clk), .rst(rst), .dir_i(dir_i), .dir_float_i(dir_float_i),
    .off_i(off_i), .off_float_i(off_float_i), .on_i(on_i), .on_float_i(on_float_i),
    .flt_pulse_i(flt_pulse_i), .uv_i(uv_i),
    .leg_o(leg_o), .flag_n_o(flag_n_o), .stat_o(stat_o)
  );

  function automatic logic [2*NL-1:0] drive(bit run, logic [NL-1:0] d);
    logic [2*NL-1:0] r;
    for (int g = 0; g < NL; g++) r[2*g +: 2] = !run ? 2'b00 : (d[g] ? 2'b10 : 2'b01);
    return r;
  endfunction

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(logic [2*NL-1:0] legs, logic flag, logic [FW:0] stat, string tag);
    exp_t e;
    wait_cycles(SETTLE);
    e.legs = legs; e.flag = flag; e.stat = stat; e.tag = tag;
    sb.push_back(e);
    wait_cycles(1);
  endtask

  task automatic pulse_fault(logic [FW-1:0] v);
    @(negedge clk);
    flt_pulse_i = v;
    @(negedge clk);
    flt_pulse_i = '0;
  endtask

  // monitor: pops expected items and compares them away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (leg_o !== e.legs || flag_n_o !== e.flag || stat_o !== e.stat) begin
          errors++;
          $display("FAIL %s: actual legs=%b flag=%b stat=%b expected legs=%b flag=%b stat=%b",
                   e.tag, leg_o, flag_n_o, stat_o, e.legs, e.flag, e.stat);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(4);
    @(negedge clk) rst = 1'b0;
    expect_state(drive(0, '0), 1'b1, '0, "R8 reset state");

    // R1 main drive patterns
    off_i = 1'b0; on_i = 1'b1; dir_i = 2'b01;
    expect_state(drive(1, 2'b01), 1'b1, '0, "R1 dir=01");
    dir_i = 2'b10;
    expect_state(drive(1, 2'b10), 1'b1, '0, "R1 dir=10");
    dir_i = 2'b00;
    expect_state(drive(1, 2'b00), 1'b1, '0, "R1 dir=00");
    dir_i = 2'b11;
    expect_state(drive(1, 2'b11), 1'b1, '0, "R1 dir=11");

    // R2 disable and enable
    off_i = 1'b1;
    expect_state(drive(0, '0), 1'b1, '0, "R2 disable high");
    off_i = 1'b0; on_i = 1'b0;
    expect_state(drive(0, '0), 1'b1, '0, "R2 enable low");
    on_i = 1'b1;

    // R3 floating pins read tie values
    dir_i = 2'b00; dir_float_i = 2'b01;
    expect_state(drive(1, 2'b01), 1'b1, '0, "R3 floating direction reads high");
    dir_float_i = '0; off_float_i = 1'b1;
    expect_state(drive(0, '0), 1'b1, '0, "R3 floating disable reads high");
    off_float_i = 1'b0; on_float_i = 1'b1;
    expect_state(drive(0, '0), 1'b1, '0, "R3 floating enable reads low");
    on_float_i = 1'b0;
    expect_state(drive(1, 2'b00), 1'b1, '0, "R3 pins reconnected");

    // R5 undervoltage is live
    uv_i = 1'b1;
    expect_state(drive(0, '0), 1'b0, 7'b1000000, "R5 undervoltage present");
    uv_i = 1'b0;
    expect_state(drive(1, 2'b00), 1'b1, '0, "R5 undervoltage recovered");

    // R4 R6 R7 ground short on leg 1 (bit 3), cleared by disable falling edge
    dir_i = 2'b10;
    pulse_fault(6'b001000);
    expect_state(drive(0, '0), 1'b0, 7'b0001000, "R4 R6 ground short latched");
    off_i = 1'b1;
    expect_state(drive(0, '0), 1'b0, 7'b0001000, "R7 disable rise keeps fault");
    off_i = 1'b0;
    expect_state(drive(1, 2'b10), 1'b1, '0, "R7 disable fall clears");

    // R6 R7 over-temperature (bit 5), cleared by enable rising edge
    pulse_fault(6'b100000);
    expect_state(drive(0, '0), 1'b0, 7'b0100000, "R6 overtemp latched");
    on_i = 1'b0;
    expect_state(drive(0, '0), 1'b0, 7'b0100000, "R7 enable fall keeps fault");
    on_i = 1'b1;
    expect_state(drive(1, 2'b10), 1'b1, '0, "R7 enable rise clears");

    // R6 two faults together: supply short leg 0 (bit 0) and cross-load (bit 4)
    pulse_fault(6'b010001);
    expect_state(drive(0, '0), 1'b0, 7'b0010001, "R6 combined faults");

    // R8 power-on reset clears the latch
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    expect_state(drive(1, 2'b10), 1'b1, '0, "R8 reset clears faults");

    wait (sb.size() == 0);
    wait_cycles(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule